// File: doc/BRIEF.md
# FIFO-Buffered Serial Transmitter

This block is the transmit half of a classic asynchronous serial port. The host writes bytes into a holding port. Depending on a mode input, each byte is either queued in a 16-entry first-in first-out buffer or kept in a single holding register. A shift engine takes the bytes one at a time and sends each one as a serial frame. The shift engine is paced by a 16x oversampling enable (`tick16`) that comes from an external baud divider. The frame is a low start bit, then 5 to 8 data bits with the least-significant bit first, then an optional parity bit, then a high stop period.

The host gets two status flags. `hold_empty` reports that the holding storage can take data. `tx_empty` reports that the whole path has gone quiet. A transmit interrupt request tells the host when to refill. In buffered mode the request fires when the queue level drops below a selectable threshold. In single-register mode it fires when the byte leaves the holding register. A break input forces the line low.

Line settings are taken when a frame starts. They should therefore change only while `tx_empty` is high. The same holds for the mode input.

Top module: `uart_tx_path`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1, `tx_empty` is 1 and `irq` is 0.
- R2: A frame starts with one low bit, followed by the data bits least-significant first. The number of data bits is 5 + `word_len`, so codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Each bit lasts 16 `tick16` pulses.
- R3: When `par_en` is 1, a parity bit follows the data. `par_kind` selects it: 0 makes the total number of ones odd, 1 makes it even, 2 sends a constant 1, and 3 sends a constant 0.
- R4: The stop period is high. It lasts 16 ticks when `stop2` is 0. When `stop2` is 1 it lasts 32 ticks, or 24 ticks for 5-bit words. With one tick per clock, a single frame occupies 16·(1 + data bits + parity) + stop ticks cycles, measured from the start edge to `tx_empty` rising.
- R5: While `brk` is 1, `txd` is 0 in the same cycle, whatever the shift state.
- R6: With `fifo_en` = 1, up to 16 queued bytes plus the byte in the shift engine are sent in write order. A write while the queue holds 16 bytes is dropped.
- R7: With `fifo_en` = 1, `hold_empty` is 1 exactly when the queue holds no byte.
- R8: With `fifo_en` = 0, `hold_empty` goes to 0 on a write. It returns to 1 in the cycle after the byte moves into an idle shift engine, and stays 0 while the engine is busy.
- R9: `tx_empty` is 1 only when the holding storage is empty and no frame is in progress. A write makes it 0 on the next cycle.
- R10: In buffered mode, a request becomes pending when the queue level falls from at least the threshold to below it. `trig_sel` codes 0, 1, 2 and 3 give thresholds of 1, 4, 8 and 14 entries.
- R11: A write clears the pending request. In single-register mode a request becomes pending when `hold_empty` rises.
- R12: `irq` is the pending request gated by `irq_en`. While `irq_en` is 0, `irq` stays 0 and the pending state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | 16x bit-rate enable |
| wr_en | input | 1 | Holding-port write strobe |
| wr_data | input | 8 | Byte to send |
| fifo_en | input | 1 | 1 selects the 16-entry queue, 0 selects the single register |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_kind | input | 2 | 0 odd, 1 even, 2 constant 1, 3 constant 0 |
| stop2 | input | 1 | Long stop period |
| brk | input | 1 | Force line low |
| trig_sel | input | 2 | Threshold select: 1, 4, 8 or 14 entries |
| irq_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding storage can accept data |
| tx_empty | output | 1 | Storage and shift engine both idle |
| irq | output | 1 | Transmit interrupt request |

## Verification
Each fault has a distinct signature at the ports:
- A wrong bit counter or tick counter shows up on `txd` within one frame, as a shifted or missing data bit. It also changes the frame length, which the bench measures exactly for every word length, parity kind and stop setting.
- Queue pointer or count errors show up as bytes out of order, a missing byte or an extra byte after a 17-byte burst.
- A wrong level comparison moves the interrupt to the wrong frame. The bench checks it at the start of the second and third frames for every threshold.
- Flag errors show up in the one or two cycles after a write or a load into the shift engine. The bench samples at exactly those cycles.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DW = 8;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_BITS = 2'd1,
        SH_STOP = 2'd2
    } sh_state_e;

    typedef enum logic [1:0] {
        PAR_ODD  = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ONE  = 2'd2,
        PAR_ZERO = 2'd3
    } par_kind_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        par_kind_e  par_kind;
        logic       stop2;
    } line_cfg_t;

    function automatic logic [3:0] word_bits(input logic [1:0] wlen);
        return 4'd5 + {2'b00, wlen};
    endfunction

    function automatic logic par_bit(input logic [DW-1:0] d, input logic [1:0] wlen,
                                     input par_kind_e kind);
        logic [DW-1:0] mask;
        logic          ones;
        mask = 8'hFF >> (2'd3 - wlen);
        ones = ^(d & mask);
        case (kind)
            PAR_ODD:  return ~ones;
            PAR_EVEN: return ones;
            PAR_ONE:  return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push, pop;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign push  = wr && !full;
    assign pop   = rd && !empty;
    assign rdata = mem[rp];
    assign count = cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R6: a write into a full queue with no read leaves the level unchanged
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (wr && full && !rd) |=> $stable(cnt));

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            rdata <= '0;
        end else if (wr) begin
            valid <= 1'b1;
            rdata <= wdata;
        end else if (rd) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  line_cfg_t     cfg,
    input  logic          avail,
    input  logic [DW-1:0] din,
    output logic          take,
    output logic          idle,
    output logic          line
);
    localparam int FW = DW + 2;
    localparam int TW = $clog2(2 * OS + 1);
    localparam int BW = $clog2(FW + 1);
    localparam logic [TW-1:0] ST1  = TW'(OS);
    localparam logic [TW-1:0] ST15 = TW'(OS + OS / 2);
    localparam logic [TW-1:0] ST2  = TW'(2 * OS);

    sh_state_e     state;
    logic [FW-1:0] sh, fr;
    logic [TW-1:0] tcnt, stop_len;
    logic [BW-1:0] left;
    logic [3:0]    wb, nb;

    always_comb begin
        wb = word_bits(cfg.wlen);
        fr = '1;
        fr[0] = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (4'(i) < wb) fr[i+1] = din[i];
        end
        if (cfg.par_en) fr[int'(wb) + 1] = par_bit(din, cfg.wlen, cfg.par_kind);
        nb = wb + {3'b000, cfg.par_en} + 4'd1;
    end

    assign idle = (state == SH_IDLE);
    assign take = idle && avail;
    assign line = (state == SH_BITS) ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SH_IDLE;
            sh       <= '1;
            tcnt     <= '0;
            left     <= '0;
            stop_len <= ST1;
        end else begin
            case (state)
                SH_IDLE: begin
                    if (avail) begin
                        sh       <= fr;
                        left     <= BW'(nb);
                        tcnt     <= '0;
                        stop_len <= cfg.stop2 ? ((cfg.wlen == 2'd0) ? ST15 : ST2) : ST1;
                        state    <= SH_BITS;
                    end
                end
                SH_BITS: begin
                    if (tick) begin
                        if (tcnt == TW'(OS - 1)) begin
                            tcnt <= '0;
                            sh   <= {1'b1, sh[FW-1:1]};
                            if (left == BW'(1)) state <= SH_STOP;
                            else                left  <= left - 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                SH_STOP: begin
                    if (tick) begin
                        if (tcnt == stop_len - 1'b1) begin
                            tcnt  <= '0;
                            state <= SH_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    // R2: without a tick, a bit on the line never changes
    a_r2_bit_holds: assert property (@(posedge clk) disable iff (rst)
        (state == SH_BITS && !tick) |=> (state == SH_BITS && $stable(line)));

    // R4: the stop period only ends on a tick
    a_r4_stop_waits: assert property (@(posedge clk) disable iff (rst)
        (state == SH_STOP && !tick) |=> (state == SH_STOP));

endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq
    import uart_tx_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_mode,
    input  logic          wr,
    input  logic [CW-1:0] count,
    input  logic          hold_empty,
    input  logic [1:0]    trig_sel,
    output logic          pend
);
    logic [CW-1:0] cnt_d, lvl;
    logic          he_d, fire;

    assign lvl  = CW'(trig_level(trig_sel));
    assign fire = fifo_mode ? ((cnt_d >= lvl) && (count < lvl))
                            : (hold_empty && !he_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_d <= '0;
            he_d  <= 1'b1;
            pend  <= 1'b0;
        end else begin
            cnt_d <= count;
            he_d  <= hold_empty;
            if (wr)        pend <= 1'b0;
            else if (fire) pend <= 1'b1;
        end
    end

    // R11: a host write always leaves the request cleared
    a_r11_write_clears: assert property (@(posedge clk) disable iff (rst)
        wr |=> !pend);

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OS    = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick16,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          fifo_en,
    input  logic [1:0]    word_len,
    input  logic          par_en,
    input  logic [1:0]    par_kind,
    input  logic          stop2,
    input  logic          brk,
    input  logic [1:0]    trig_sel,
    input  logic          irq_en,
    output logic          txd,
    output logic          hold_empty,
    output logic          tx_empty,
    output logic          irq
);
    localparam int CW = $clog2(DEPTH + 1);

    line_cfg_t     cfg;
    logic [DW-1:0] f_data, h_data, s_data;
    logic          f_empty, f_full, h_valid;
    logic [CW-1:0] f_count;
    logic          take, s_idle, s_line, avail, pend;

    assign cfg = '{wlen: word_len, par_en: par_en,
                   par_kind: par_kind_e'(par_kind), stop2: stop2};

    uart_tx_fifo #(.DEPTH(DEPTH), .W(DW)) u_fifo (
        .clk(clk), .rst(rst),
        .wr(wr_en && fifo_en), .wdata(wr_data),
        .rd(take && fifo_en), .rdata(f_data),
        .empty(f_empty), .full(f_full), .count(f_count)
    );

    uart_tx_hold #(.W(DW)) u_hold (
        .clk(clk), .rst(rst),
        .wr(wr_en && !fifo_en), .wdata(wr_data),
        .rd(take && !fifo_en), .rdata(h_data), .valid(h_valid)
    );

    assign avail      = fifo_en ? !f_empty : h_valid;
    assign s_data     = fifo_en ? f_data : h_data;
    assign hold_empty = fifo_en ? f_empty : !h_valid;

    uart_tx_shifter #(.OS(OS)) u_shift (
        .clk(clk), .rst(rst), .tick(tick16), .cfg(cfg),
        .avail(avail), .din(s_data), .take(take),
        .idle(s_idle), .line(s_line)
    );

    uart_tx_irq #(.CW(CW)) u_irq (
        .clk(clk), .rst(rst), .fifo_mode(fifo_en), .wr(wr_en),
        .count(f_count), .hold_empty(hold_empty),
        .trig_sel(trig_sel), .pend(pend)
    );

    assign tx_empty = hold_empty && s_idle;
    assign txd      = brk ? 1'b0 : s_line;
    assign irq      = pend && irq_en;

    // R9: a write always makes the path busy on the next cycle
    a_r9_write_busy: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tx_empty);

    // R6: a full queue keeps the holding storage reported as occupied
    a_r6_full_not_empty: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && f_full) |-> !hold_empty);

endmodule

// File: tb/uart_tx_path_test.sv
module uart_tx_path_test;
    logic       clk = 0, rst = 1, tick_on = 0, wr_en = 0, fifo_en = 0;
    logic       par_en = 0, stop2 = 0, brk = 0, irq_en = 0;
    logic [7:0] wr_data = 0;
    logic [1:0] wlen = 2'd3, par_kind = 2'd0, trig_sel = 2'd0;
    wire        txd, hold_empty, tx_empty, irq;
    int         n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    uart_tx_path uut (
        .clk(clk), .rst(rst), .tick16(tick_on), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_en(fifo_en), .word_len(wlen), .par_en(par_en), .par_kind(par_kind),
        .stop2(stop2), .brk(brk), .trig_sel(trig_sel), .irq_en(irq_en),
        .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic wait_next_start();
        while (txd !== 1'b1) @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 5000 && tx_empty !== 1'b1; g++) @(negedge clk);
    endtask

    task automatic capture(input int nb, input bit do_len, output logic [9:0] bits,
                           output bit stop_ok, output int len);
        int c;
        while (txd !== 1'b0) @(negedge clk);
        bits = '1; stop_ok = 0; c = 0;
        while (c <= nb * 16 + 8) begin
            if (c % 16 == 8) begin
                if (c / 16 < nb) bits[c/16] = txd;
                else             stop_ok = (txd === 1'b1);
            end
            @(negedge clk); c++;
        end
        if (do_len) begin
            while (tx_empty !== 1'b1 && c < 1000) begin @(negedge clk); c++; end
        end
        len = c;
    endtask

    function automatic int thresh(input int s);
        case (s) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        logic [9:0] bits, ebits;
        bit         stop_ok;
        int         len;

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(txd === 1'b1,        "R1 txd",        int'(txd), 1);
        chk(hold_empty === 1'b1, "R1 hold_empty", int'(hold_empty), 1);
        chk(tx_empty === 1'b1,   "R1 tx_empty",   int'(tx_empty), 1);
        chk(irq === 1'b0,        "R1 irq",        int'(irq), 0);

        // R5 break forces line low, release restores idle high
        @(negedge clk); brk = 1; #1;
        chk(txd === 1'b0, "R5 break low", int'(txd), 0);
        @(negedge clk); brk = 0; #1;
        chk(txd === 1'b1, "R5 break released", int'(txd), 1);

        // R8 / R11 single-register mode flags and request
        fifo_en = 0; irq_en = 1; tick_on = 0; wlen = 2'd3;
        write_byte(8'h5A);
        chk(hold_empty === 1'b0, "R8 held after write", int'(hold_empty), 0);
        chk(irq === 1'b0, "R11 no request yet", int'(irq), 0);
        @(negedge clk);
        chk(hold_empty === 1'b1, "R8 empty after transfer", int'(hold_empty), 1);
        chk(tx_empty === 1'b0, "R9 shifter busy", int'(tx_empty), 0);
        @(negedge clk);
        chk(irq === 1'b1, "R11 request on holding empty", int'(irq), 1);
        write_byte(8'hC3);
        chk(irq === 1'b0, "R11 write clears request", int'(irq), 0);
        repeat (5) @(negedge clk);
        chk(hold_empty === 1'b0, "R8 stays held while busy", int'(hold_empty), 0);
        tick_on = 1;
        wait_idle();
        chk(tx_empty === 1'b1, "R9 drained", int'(tx_empty), 1);
        irq_en = 0;

        // R7 queue-mode holding flag
        @(negedge clk); fifo_en = 1; tick_on = 0;
        write_byte(8'h11);
        chk(hold_empty === 1'b0, "R7 queue holds byte", int'(hold_empty), 0);
        @(negedge clk);
        chk(hold_empty === 1'b1, "R7 queue empty after load", int'(hold_empty), 1);
        write_byte(8'h22);
        repeat (5) @(negedge clk);
        chk(hold_empty === 1'b0, "R7 queue nonempty", int'(hold_empty), 0);
        chk(tx_empty === 1'b0, "R9 not empty with queued byte", int'(tx_empty), 0);
        tick_on = 1;
        wait_idle();
        chk(tx_empty === 1'b1, "R9 drained queue", int'(tx_empty), 1);

        // R2 R3 R4 sweep of word length, parity kind and stop length
        for (int idx = 0; idx < 40; idx++) begin
            int wl, pm, s2, wb, nb, exp_len;
            logic [7:0] d;
            logic pbit, ones;
            wl = idx % 4; pm = (idx / 4) % 5; s2 = idx / 20;
            wb = 5 + wl; nb = 1 + wb + (pm != 4 ? 1 : 0);
            d = 8'(idx * 37 + 11);
            ones = 0;
            for (int i = 0; i < wb; i++) ones ^= d[i];
            case (pm) 0: pbit = ~ones; 1: pbit = ones; 2: pbit = 1'b1; default: pbit = 1'b0; endcase
            ebits = '1; ebits[0] = 1'b0;
            for (int i = 0; i < wb; i++) ebits[i+1] = d[i];
            if (pm != 4) ebits[wb+1] = pbit;
            exp_len = 16 * nb + (s2 == 0 ? 16 : (wl == 0 ? 24 : 32));
            @(negedge clk);
            wlen = 2'(wl); par_en = (pm != 4); par_kind = 2'(pm); stop2 = s2[0];
            fifo_en = idx[0]; tick_on = 1;
            write_byte(d);
            capture(nb, 1, bits, stop_ok, len);
            chk(bits == ebits, "R2 frame bits", int'(bits), int'(ebits));
            if (pm != 4) chk(bits[wb+1] === pbit, "R3 parity bit", int'(bits[wb+1]), int'(pbit));
            chk(stop_ok, "R4 stop high", int'(stop_ok), 1);
            chk(len == exp_len, "R4 frame length", len, exp_len);
        end

        // R6 overflow: 17 bytes accepted, 18th dropped, order kept
        @(negedge clk);
        fifo_en = 1; tick_on = 0; wlen = 2'd3; par_en = 0; stop2 = 0;
        for (int i = 0; i < 17; i++) write_byte(8'(8'h40 + i));
        write_byte(8'hFF);
        chk(hold_empty === 1'b0, "R7 full queue held", int'(hold_empty), 0);
        tick_on = 1;
        for (int i = 0; i < 17; i++) begin
            capture(9, 0, bits, stop_ok, len);
            chk(bits[8:1] == 8'(8'h40 + i), "R6 byte order", int'(bits[8:1]), 8'h40 + i);
        end
        repeat (20) @(negedge clk);
        chk(tx_empty === 1'b1, "R6 dropped write not sent", int'(tx_empty), 1);

        // R10 R11 R12 threshold sweep, last pass with request masked
        for (int pass = 0; pass < 5; pass++) begin
            int ts, t;
            bit en;
            ts = (pass < 4) ? pass : 1; en = (pass < 4);
            t = thresh(ts);
            @(negedge clk);
            fifo_en = 1; trig_sel = 2'(ts); irq_en = en; tick_on = 0;
            wlen = 2'd0; par_en = 0; stop2 = 0;
            for (int i = 0; i < t + 2; i++) write_byte(8'h1F);
            chk(irq === 1'b0, "R10 no request while filling", int'(irq), 0);
            tick_on = 1;
            wait_next_start();
            repeat (2) @(negedge clk);
            chk(irq === 1'b0, "R10 level at threshold", int'(irq), 0);
            wait_next_start();
            repeat (2) @(negedge clk);
            chk(irq === en, "R10 level below threshold", int'(irq), int'(en));
            if (!en) begin
                chk(irq === 1'b0, "R12 masked", int'(irq), 0);
                irq_en = 1; #1;
                chk(irq === 1'b1, "R12 pending kept while masked", int'(irq), 1);
            end
            write_byte(8'h1F);
            chk(irq === 1'b0, "R11 write clears queue request", int'(irq), 0);
            wait_idle();
        end

        finish_run();
    end
endmodule